// File: doc/BRIEF.md
# Paged Nonvolatile Memory Controller

This controller fronts a register-based model of a nonvolatile array split into three regions: a program flash region built from pages of 16-bit words, a data EEPROM region built from pages of bytes, and a user signature region the size of exactly one flash page. A single command port carries a 3-bit operation code, a 2-bit region selector, a byte address and 16 bits of data. Reads return one byte in the next cycle. Writes are staged in a page buffer and then committed. Erase and program operations hold a busy flag for a fixed number of cycles and update the array when that flag drops.

The address is split by region. For flash, the low bit selects the byte inside a word, the next bits select the word inside the page, and the remaining high bits select the page. For EEPROM and the signature region, the low bits give the byte offset and, for EEPROM, the high bits give the page. Erased cells read 0xFF. Programming can only clear bits, so a write stores the AND of the new and old contents. Chip erase restores the flash and EEPROM regions and leaves the signature region as it is. Only the signature-erase command clears the signature region.

Top module: `nvm_ctrl`

## Requirements
- R1: After reset, every byte of every region reads 0xFF, and busy, err and rd_valid are low.
- R2: A READ (code 0) accepted at a clock edge raises rd_valid for one cycle after that edge, with the addressed byte on rd_data. Regions are encoded as 0 = flash, 1 = EEPROM, 2 = signature. In flash, address bit 0 selects the low (0) or high (1) byte of the word.
- R3: A LOAD (code 1) to flash or signature places cmd_data[7:0] in page-buffer byte 2w and cmd_data[15:8] in byte 2w+1, where w is address bits [3:1]. A LOAD to EEPROM places cmd_data[7:0] at the byte offset given by address bits [2:0].
- R4: A PAGE_WRITE (code 2) commits the page buffer to the addressed page of the selected region. Buffer bytes that were not loaded leave the array unchanged. The buffer returns to all ones after the commit.
- R5: A PAGE_ERASE (code 3) on flash sets every byte of the addressed page (address bits [5:4]) to 0xFF and leaves the other pages unchanged.
- R6: BYTE_WRITE (code 4) and BYTE_ERASE (code 5) on EEPROM change only the addressed byte.
- R7: PAGE_WRITE and PAGE_ERASE on EEPROM act on the 8-byte page selected by address bits [4:3].
- R8: CHIP_ERASE (code 6) sets all flash and EEPROM bytes to 0xFF and leaves the signature region unchanged.
- R9: SIG_ERASE (code 7) sets the signature region to 0xFF and leaves flash and EEPROM unchanged.
- R10: An accepted write or erase holds busy high for exactly OP_LAT cycles (default 5). The array shows the result once busy has dropped.
- R11: A command presented while busy is high is rejected: err is high for the following cycle and the array is unchanged.
- R12: Illegal combinations raise err for one cycle and have no effect. These are byte operations outside EEPROM, PAGE_ERASE on the signature region, and any READ, LOAD, PAGE_WRITE or PAGE_ERASE naming region 3.
- R13: Writing to a location that is already programmed stores the bitwise AND of the old and new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_code | input | 3 | Operation code |
| cmd_region | input | 2 | Region selector |
| cmd_addr | input | 6 | Byte address within region |
| cmd_data | input | 16 | Load word or byte-write data |
| busy | output | 1 | Erase or write in progress |
| err | output | 1 | Command rejected (one-cycle pulse) |
| rd_valid | output | 1 | rd_data holds a read result |
| rd_data | output | 8 | Read byte |

## Verification
The hardest case to reach from the ports is the AND behaviour of a second write over programmed cells, together with proof that the buffer was cleared by the first commit. The stimulus programs one flash word, loads an overlapping pattern and commits again, then commits once more with no load, reading back after each commit. Rejection while busy is reached by issuing a second command one cycle after an erase starts. The target byte is then read after busy drops to confirm that it did not change.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
    typedef enum logic [2:0] {
        CMD_READ       = 3'd0,
        CMD_LOAD       = 3'd1,
        CMD_PAGE_WRITE = 3'd2,
        CMD_PAGE_ERASE = 3'd3,
        CMD_BYTE_WRITE = 3'd4,
        CMD_BYTE_ERASE = 3'd5,
        CMD_CHIP_ERASE = 3'd6,
        CMD_SIG_ERASE  = 3'd7
    } nvm_cmd_e;

    typedef enum logic [1:0] {
        REG_FLASH  = 2'd0,
        REG_EEPROM = 2'd1,
        REG_SIG    = 2'd2,
        REG_NONE   = 2'd3
    } nvm_region_e;
endpackage

// File: rtl/nvm_addr_split.sv
module nvm_addr_split #(
    parameter int AW  = 6,
    parameter int FAW = 6,
    parameter int FOB = 4,
    parameter int EAW = 5,
    parameter int EOB = 3
) (
    input  logic [AW-1:0]  addr,
    output logic [FAW-1:0] f_byte,
    output logic [FAW-1:0] f_base,
    output logic [FOB-2:0] w_off,
    output logic [EAW-1:0] e_byte,
    output logic [EAW-1:0] e_base,
    output logic [EOB-1:0] e_off,
    output logic [FOB-1:0] s_byte
);
    always_comb begin
        f_byte = addr[FAW-1:0];
        f_base = {addr[FAW-1:FOB], {FOB{1'b0}}};
        w_off  = addr[FOB-1:1];
        e_byte = addr[EAW-1:0];
        e_base = {addr[EAW-1:EOB], {EOB{1'b0}}};
        e_off  = addr[EOB-1:0];
        s_byte = addr[FOB-1:0];
    end
endmodule

// File: rtl/nvm_op_timer.sv
module nvm_op_timer #(
    parameter int OP_LAT = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = (OP_LAT < 2) ? 1 : $clog2(OP_LAT);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    assign busy = t_q.busy;
    assign done = t_q.busy && (t_q.cnt == '0);

    always_comb begin
        t_d = t_q;
        if (start) begin
            t_d.busy = 1'b1;
            t_d.cnt  = CW'(OP_LAT - 1);
        end else if (done) begin
            t_d.busy = 1'b0;
        end else if (t_q.busy) begin
            t_d.cnt = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end
endmodule

// File: rtl/nvm_page_buf.sv
module nvm_page_buf #(
    parameter int FOB = 4,
    parameter int EOB = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic                          word_mode,
    input  logic [FOB-2:0]                w_off,
    input  logic [EOB-1:0]                b_off,
    input  logic [15:0]                   data,
    input  logic                          clear,
    output logic [(1<<FOB)-1:0][7:0]      pbuf
);
    localparam int PB = 1 << FOB;

    logic [PB-1:0][7:0] b_d, b_q;

    assign pbuf = b_q;

    always_comb begin
        b_d = b_q;
        if (clear) begin
            b_d = '1;
        end else if (load) begin
            if (word_mode) begin
                b_d[{w_off, 1'b0}] = data[7:0];
                b_d[{w_off, 1'b1}] = data[15:8];
            end else begin
                b_d[FOB'(b_off)] = data[7:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) b_q <= '1;
        else        b_q <= b_d;
    end
endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
    import nvm_pkg::*;
#(
    parameter int FLASH_PAGES = 4,
    parameter int PAGE_WORDS  = 8,
    parameter int EE_PAGES    = 4,
    parameter int EE_PAGE_B   = 8,
    parameter int OP_LAT      = 5,
    localparam int FPB    = PAGE_WORDS * 2,
    localparam int FBYTES = FLASH_PAGES * FPB,
    localparam int EBYTES = EE_PAGES * EE_PAGE_B,
    localparam int FAW    = $clog2(FBYTES),
    localparam int EAW    = $clog2(EBYTES),
    localparam int AW     = (FAW > EAW) ? FAW : EAW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_code,
    input  logic [1:0]    cmd_region,
    input  logic [AW-1:0] cmd_addr,
    input  logic [15:0]   cmd_data,
    output logic          busy,
    output logic          err,
    output logic          rd_valid,
    output logic [7:0]    rd_data
);
    localparam int FOB = $clog2(FPB);
    localparam int EOB = $clog2(EE_PAGE_B);

    typedef struct packed {
        logic [FBYTES-1:0][7:0] flash;
        logic [EBYTES-1:0][7:0] ee;
        logic [FPB-1:0][7:0]    sig;
        logic                   err;
        logic                   rd_valid;
        logic [7:0]             rd_data;
        nvm_cmd_e               p_cmd;
        nvm_region_e            p_reg;
        logic [AW-1:0]          p_addr;
        logic [7:0]             p_data;
    } st_t;

    st_t s_d, s_q;

    nvm_cmd_e           cmd;
    nvm_region_e        reg_sel;
    logic               start, done, legal, load, clear;
    logic [AW-1:0]      addr_sel;
    logic [FAW-1:0]     f_byte, f_base;
    logic [FOB-2:0]     w_off;
    logic [EAW-1:0]     e_byte, e_base;
    logic [EOB-1:0]     e_off;
    logic [FOB-1:0]     s_byte;
    logic [FPB-1:0][7:0] pbuf;

    assign cmd     = nvm_cmd_e'(cmd_code);
    assign reg_sel = nvm_region_e'(cmd_region);
    // Live commands are refused while busy, so the pending address owns the split then.
    assign addr_sel = busy ? s_q.p_addr : cmd_addr;
    assign clear    = done && (s_q.p_cmd == CMD_PAGE_WRITE);

    nvm_addr_split #(.AW(AW), .FAW(FAW), .FOB(FOB), .EAW(EAW), .EOB(EOB)) i_split (
        .addr(addr_sel), .f_byte(f_byte), .f_base(f_base), .w_off(w_off),
        .e_byte(e_byte), .e_base(e_base), .e_off(e_off), .s_byte(s_byte)
    );

    nvm_op_timer #(.OP_LAT(OP_LAT)) i_timer (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done)
    );

    nvm_page_buf #(.FOB(FOB), .EOB(EOB)) i_pbuf (
        .clk(clk), .rst_n(rst_n), .load(load), .word_mode(reg_sel != REG_EEPROM),
        .w_off(w_off), .b_off(e_off), .data(cmd_data), .clear(clear), .pbuf(pbuf)
    );

    always_comb begin
        s_d          = s_q;
        s_d.err      = 1'b0;
        s_d.rd_valid = 1'b0;
        start        = 1'b0;
        load         = 1'b0;
        legal        = 1'b0;

        if (cmd_valid) begin
            if (busy) begin
                s_d.err = 1'b1;
            end else begin
                case (cmd)
                    CMD_READ: begin
                        legal = (reg_sel != REG_NONE);
                        s_d.rd_valid = legal;
                        case (reg_sel)
                            REG_FLASH:  s_d.rd_data = s_q.flash[f_byte];
                            REG_EEPROM: s_d.rd_data = s_q.ee[e_byte];
                            REG_SIG:    s_d.rd_data = s_q.sig[s_byte];
                            default:    s_d.rd_data = s_q.rd_data;
                        endcase
                    end
                    CMD_LOAD: begin
                        legal = (reg_sel != REG_NONE);
                        load  = legal;
                    end
                    CMD_PAGE_WRITE: legal = (reg_sel != REG_NONE);
                    CMD_PAGE_ERASE: legal = (reg_sel == REG_FLASH) || (reg_sel == REG_EEPROM);
                    CMD_BYTE_WRITE,
                    CMD_BYTE_ERASE: legal = (reg_sel == REG_EEPROM);
                    default:        legal = 1'b1;
                endcase
                if (legal && (cmd != CMD_READ) && (cmd != CMD_LOAD)) begin
                    start      = 1'b1;
                    s_d.p_cmd  = cmd;
                    s_d.p_reg  = reg_sel;
                    s_d.p_addr = cmd_addr;
                    s_d.p_data = cmd_data[7:0];
                end
                s_d.err = !legal;
            end
        end

        if (done) begin
            case (s_q.p_cmd)
                CMD_PAGE_WRITE: begin
                    case (s_q.p_reg)
                        REG_FLASH: begin
                            for (int i = 0; i < FPB; i++) begin
                                s_d.flash[f_base + FAW'(i)] =
                                    s_q.flash[f_base + FAW'(i)] & pbuf[FOB'(i)];
                            end
                        end
                        REG_EEPROM: begin
                            for (int i = 0; i < EE_PAGE_B; i++) begin
                                s_d.ee[e_base + EAW'(i)] =
                                    s_q.ee[e_base + EAW'(i)] & pbuf[FOB'(i)];
                            end
                        end
                        REG_SIG: begin
                            for (int i = 0; i < FPB; i++) begin
                                s_d.sig[FOB'(i)] = s_q.sig[FOB'(i)] & pbuf[FOB'(i)];
                            end
                        end
                        default: ;
                    endcase
                end
                CMD_PAGE_ERASE: begin
                    if (s_q.p_reg == REG_FLASH) begin
                        for (int i = 0; i < FPB; i++) begin
                            s_d.flash[f_base + FAW'(i)] = 8'hFF;
                        end
                    end else begin
                        for (int i = 0; i < EE_PAGE_B; i++) begin
                            s_d.ee[e_base + EAW'(i)] = 8'hFF;
                        end
                    end
                end
                CMD_BYTE_WRITE: s_d.ee[e_byte] = s_q.ee[e_byte] & s_q.p_data;
                CMD_BYTE_ERASE: s_d.ee[e_byte] = 8'hFF;
                CMD_CHIP_ERASE: begin
                    s_d.flash = '1;
                    s_d.ee    = '1;
                end
                CMD_SIG_ERASE:  s_d.sig = '1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.flash    <= '1;
            s_q.ee       <= '1;
            s_q.sig      <= '1;
            s_q.p_cmd    <= CMD_READ;
            s_q.p_reg    <= REG_FLASH;
        end else begin
            s_q <= s_d;
        end
    end

    assign err      = s_q.err;
    assign rd_valid = s_q.rd_valid;
    assign rd_data  = s_q.rd_data;
endmodule

// File: rtl/nvm_ctrl_chk.sv
module nvm_ctrl_chk #(
    parameter int OP_LAT = 5
) (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic busy,
    input logic err,
    input logic rd_valid
);
    localparam int RW = $clog2(OP_LAT + 2);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + 1'b1;
        else           run_q <= '0;
    end

    // R10
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == RW'(OP_LAT)));

    // R10
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid));

    // R11
    reject_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> err);

    // R2
    read_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(cmd_valid) && !$past(busy)));

    // R12
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !rd_valid);
endmodule

bind nvm_ctrl nvm_ctrl_chk #(.OP_LAT(OP_LAT)) i_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
    .busy(busy), .err(err), .rd_valid(rd_valid)
);

// File: tb/test_nvm_ctrl.sv
module test_nvm_ctrl;
    localparam int OP_LAT = 5;
    localparam logic [2:0] RD = 0, LD = 1, PW = 2, PE = 3, BW = 4, BE = 5, CE = 6, SE = 7;
    localparam logic [1:0] FL = 0, EE = 1, SG = 2, NO = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_code = '0;
    logic [1:0]  cmd_region = '0;
    logic [5:0]  cmd_addr = '0;
    logic [15:0] cmd_data = '0;
    logic        busy, err, rd_valid;
    logic [7:0]  rd_data;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    nvm_ctrl #(.OP_LAT(OP_LAT)) i_nvm_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_region(cmd_region), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .busy(busy), .err(err), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] c, input logic [1:0] r, input int a, input int d);
        @(negedge clk);
        cmd_code = c; cmd_region = r; cmd_addr = 6'(a); cmd_data = 16'(d);
        cmd_valid = 1'b1;
        @(posedge clk);
        #1 cmd_valid = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        @(negedge clk);
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic op(input logic [2:0] c, input logic [1:0] r, input int a, input int d);
        int n;
        drive(c, r, a, d);
        wait_idle(n);
    endtask

    task automatic rd(input logic [1:0] r, input int a, input int exp, input string tag);
        drive(RD, r, a, 0);
        @(negedge clk);
        chk(rd_valid, 1, {tag, " valid"});
        chk(rd_data, exp, tag);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(busy, 0, "R1 busy");
        chk(err, 0, "R1 err");
        chk(rd_valid, 0, "R1 rd_valid");
        rd(FL, 63, 8'hFF, "R1 flash");
        rd(EE, 5, 8'hFF, "R1 eeprom");
        rd(SG, 3, 8'hFF, "R1 sig");
    endtask

    task automatic t_flash_write();
        int n;
        drive(LD, FL, 16 + 4, 16'hA55A);
        drive(PW, FL, 16, 0);
        wait_idle(n);
        chk(n, OP_LAT, "R10 busy length");
        rd(FL, 20, 8'h5A, "R3 low byte");
        rd(FL, 21, 8'hA5, "R2 high byte");
        rd(FL, 16, 8'hFF, "R4 unloaded byte");
        op(LD, FL, 20, 16'h0F0F);
        op(PW, FL, 16, 0);
        rd(FL, 20, 8'h0A, "R13 and low");
        rd(FL, 21, 8'h05, "R13 and high");
        op(PW, FL, 16, 0);
        rd(FL, 20, 8'h0A, "R4 buffer cleared");
    endtask

    task automatic t_flash_erase();
        op(LD, FL, 32, 16'h1234);
        op(PW, FL, 32, 0);
        op(PE, FL, 16, 0);
        rd(FL, 20, 8'hFF, "R5 erased page");
        rd(FL, 32, 8'h34, "R5 other page");
    endtask

    task automatic t_eeprom();
        op(BW, EE, 10, 8'h3C);
        rd(EE, 10, 8'h3C, "R6 byte write");
        rd(EE, 11, 8'hFF, "R6 neighbour");
        op(BE, EE, 10, 0);
        rd(EE, 10, 8'hFF, "R6 byte erase");
        op(LD, EE, 1, 8'h77);
        op(PW, EE, 16, 0);
        rd(EE, 17, 8'h77, "R7 page write");
        rd(EE, 16, 8'hFF, "R7 unloaded");
        op(PE, EE, 16, 0);
        rd(EE, 17, 8'hFF, "R7 page erase");
    endtask

    task automatic t_busy_reject();
        int n;
        drive(PE, FL, 0, 0);
        drive(BW, EE, 3, 8'h00);
        @(negedge clk);
        chk(err, 1, "R11 err on busy");
        wait_idle(n);
        rd(EE, 3, 8'hFF, "R11 no effect");
    endtask

    task automatic t_illegal();
        drive(BW, FL, 32, 8'h00);
        @(negedge clk);
        chk(err, 1, "R12 byte op on flash");
        @(negedge clk);
        chk(err, 0, "R12 err one cycle");
        rd(FL, 32, 8'h34, "R12 flash unchanged");
        drive(PE, SG, 0, 0);
        @(negedge clk);
        chk(err, 1, "R12 page erase sig");
        chk(busy, 0, "R12 no busy");
        drive(RD, NO, 0, 0);
        @(negedge clk);
        chk(err, 1, "R12 region 3 err");
        chk(rd_valid, 0, "R12 region 3 no data");
    endtask

    task automatic t_chip_sig();
        op(LD, SG, 0, 16'hBEEF);
        op(PW, SG, 0, 0);
        rd(SG, 0, 8'hEF, "R4 sig low");
        rd(SG, 1, 8'hBE, "R4 sig high");
        op(BW, EE, 2, 8'h42);
        op(CE, FL, 0, 0);
        rd(FL, 32, 8'hFF, "R8 flash erased");
        rd(EE, 2, 8'hFF, "R8 eeprom erased");
        rd(SG, 0, 8'hEF, "R8 sig kept");
        op(LD, FL, 0, 16'h1111);
        op(PW, FL, 0, 0);
        op(BW, EE, 7, 8'h24);
        op(SE, FL, 0, 0);
        rd(SG, 0, 8'hFF, "R9 sig erased");
        rd(FL, 0, 8'h11, "R9 flash kept");
        rd(EE, 7, 8'h24, "R9 eeprom kept");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_flash_write();
        t_flash_erase();
        t_eeprom();
        t_busy_reject();
        t_illegal();
        t_chip_sig();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule